// File: doc/BRIEF.md
# Serial Receiver and Framer with Head-Entry Status and Guard Time

This block is an asynchronous serial port. Its receiver takes frames of one start bit, eight data bits sent least significant bit first, one even-parity bit and one stop bit. It times each bit from a 16x oversampling tick and samples it at mid-bit. Every received byte enters a receive queue together with three error flags of its own: parity error, missing stop bit and silent byte. A status register shows the flags of the entry at the head of the queue, a sticky overrun flag, data-ready and transmitter-idle.

The transmitter sends one byte for each write to the data offset. It uses the same frame, followed by a programmable number of stop-bit times taken from the guard-time register. Software reaches the block through a small byte-wide register port: an address, a read strobe, a write strobe, write data, and read data that follows the address combinationally.

A receive line held low for a whole character produces a single 00h entry marked as a silent byte. The receiver then waits for the line to go high again before it looks for another start bit.

Top module: `serial_port_guard`

## Requirements
- R1: A frame on `rxd` is accepted as follows. A low start bit is seen on a tick and is still low 8 ticks later. Data bits follow least significant bit first, each sampled 16 ticks after the previous sample, then the parity bit and the stop bit. Each accepted frame adds one queue entry. A read strobe at offset 0 returns the head byte and removes it.
- R2: The status register at offset 5 has this layout: bit0 data ready, bit1 overrun, bit2 parity error, bit3 missing stop bit, bit4 silent byte, bit5 transmitter idle. Bits 7:6 read 0. After reset it reads 20h, offset 2 reads 00h and offset 0 reads 00h.
- R3: An entry gets its parity-error flag (status bit2) when its parity bit differs from the XOR of its eight data bits, which is even parity.
- R4: An entry gets its missing-stop flag (status bit3) when the stop sample is low and the frame is not silent. The receiver then ignores the line until it is sampled high.
- R5: A frame whose start, data, parity and stop samples are all low is a silent byte. It becomes one 00h entry with status bit4 set and bit3 clear. A low period longer than one character yields only that one entry.
- R6: Status bits 4:2 show the flags of the entry at the head of the queue. After a pop they show the flags of the next entry.
- R7: A status read clears bits 4:1 from the next cycle on. Data ready is not cleared by a status read. It is 1 whenever the queue holds an entry and 0 when the queue is empty.
- R8: With offset 2 bit0 set to 1 (queue mode), up to 16 entries are held in arrival order. A frame that arrives while 16 entries are held is discarded and sets overrun. Writing offset 2 empties the queue.
- R9: With offset 2 bit0 at 0 (single mode), only one entry is held. A new frame that arrives while it is still unread replaces it and sets overrun.
- R10: When a status read falls in the same cycle as a frame completing, the overrun or head flags set by that frame stay set after the read.
- R11: The guard register at offset 6 is read/write and resets to 01h.
- R12: A write to offset 0 while the transmitter is idle sends a frame on `txd`: a low start bit, the data least significant bit first, even parity, then max(G,1) high stop-bit times, where G is the guard value. Every bit lasts 16 ticks. Status bit5 is 0 from the write until the last stop time ends. Writes to offset 0 while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | 16x oversampling strobe |
| rxd | input | 1 | Serial receive line, idle high |
| txd | output | 1 | Serial transmit line, idle high |
| addr | input | 3 | Register offset |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe (pops at offset 0, clears flags at offset 5) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |

## Verification
Two things can happen in the same cycle: a status read that clears the flags, and the stop-bit sample that completes a frame and sets overrun or loads a fresh head entry. The bench counts ticks from the start edge and raises the status read on exactly the tick that samples the stop bit. It does this once in single mode with an unread byte present, and once in queue mode with a parity-errored byte arriving into an empty queue. A later status read must still show overrun in the first case and the parity flag in the second.

// File: rtl/serial_port_guard.sv
module serial_port_guard #(
  parameter int DEPTH = 16,
  parameter int OVS   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  output logic       txd,
  input  logic [2:0] addr,
  input  logic       wr,
  input  logic       rd,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] MID = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] LST = CW'(OVS - 1);
  localparam logic [2:0] A_DATA = 3'd0, A_CTRL = 3'd2, A_STAT = 3'd5, A_GUARD = 3'd6;

  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP, R_HOLD} rx_st_t;

  rx_st_t        rx_st;
  logic [CW-1:0] rx_cnt;
  logic [2:0]    rx_bit;
  logic [7:0]    rx_sh;
  logic          rx_par, rx_seen1;

  logic          push;
  logic [10:0]   push_ent;

  logic [10:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   fcnt;
  logic          fifo_en, ovr, head_clr;
  logic [7:0]    guard;

  logic          tx_busy, tx_ph;
  logic [CW-1:0] tx_cnt;
  logic [9:0]    tx_sh;
  logic [3:0]    tx_nb;
  logic [7:0]    tx_left;

  wire rd_data = rd && addr == A_DATA;
  wire rd_stat = rd && addr == A_STAT;
  wire wr_ctrl = wr && addr == A_CTRL;
  wire empty   = fcnt == '0;
  wire pop     = rd_data && !empty;
  wire full    = fifo_en ? (fcnt == (AW+1)'(DEPTH)) : !empty;
  wire blocked = full && !pop;
  wire wr_en   = push && !blocked;
  wire ovwr    = push && blocked && !fifo_en;
  wire drop    = push && blocked && fifo_en;
  wire at_mid  = tick && rx_cnt == MID;
  wire at_end  = tick && rx_cnt == LST;

  wire [10:0] head  = mem[rp];
  wire [2:0]  hflag = (!empty && !head_clr) ? head[10:8] : 3'b000;
  wire [7:0]  stat  = {2'b00, !tx_busy, hflag, ovr, !empty};

  always_comb begin
    push     = rx_st == R_STOP && at_end;
    push_ent = {!rxd && !rx_seen1, !rxd && rx_seen1, rx_par != ^rx_sh, rx_sh};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_st <= R_IDLE; rx_cnt <= '0; rx_bit <= '0;
      rx_sh <= '0; rx_par <= 1'b0; rx_seen1 <= 1'b0;
    end else begin
      case (rx_st)
        R_IDLE: if (tick && !rxd) begin rx_st <= R_START; rx_cnt <= '0; end
        R_START: if (tick) begin
          if (rx_cnt == MID) begin
            if (rxd) rx_st <= R_IDLE;
            else begin rx_st <= R_DATA; rx_cnt <= '0; rx_bit <= '0; rx_seen1 <= 1'b0; end
          end else rx_cnt <= rx_cnt + 1'b1;
        end
        R_DATA: if (tick) begin
          if (at_end) begin
            rx_cnt <= '0; rx_sh <= {rxd, rx_sh[7:1]}; rx_seen1 <= rx_seen1 | rxd;
            rx_bit <= rx_bit + 1'b1;
            if (rx_bit == 3'd7) rx_st <= R_PAR;
          end else rx_cnt <= rx_cnt + 1'b1;
        end
        R_PAR: if (tick) begin
          if (at_end) begin
            rx_cnt <= '0; rx_par <= rxd; rx_seen1 <= rx_seen1 | rxd; rx_st <= R_STOP;
          end else rx_cnt <= rx_cnt + 1'b1;
        end
        R_STOP: if (tick) begin
          if (at_end) begin rx_cnt <= '0; rx_st <= rxd ? R_IDLE : R_HOLD; end
          else rx_cnt <= rx_cnt + 1'b1;
        end
        R_HOLD: if (tick && rxd) rx_st <= R_IDLE;
        default: rx_st <= R_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= push_ent;
    if (ovwr)  mem[rp] <= push_ent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; fcnt <= '0; fifo_en <= 1'b0; head_clr <= 1'b0;
    end else if (wr_ctrl) begin
      wp <= '0; rp <= '0; fcnt <= '0; fifo_en <= wdata[0]; head_clr <= 1'b0;
    end else begin
      if (wr_en) wp <= wp + 1'b1;
      if (pop)   rp <= rp + 1'b1;
      fcnt <= fcnt + (AW+1)'(wr_en) - (AW+1)'(pop);
      if (pop || ovwr || (wr_en && empty)) head_clr <= 1'b0;
      else if (rd_stat)                    head_clr <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ovr <= 1'b0;
    else if (drop || ovwr)   ovr <= 1'b1;
    else if (rd_stat)        ovr <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       guard <= 8'h01;
    else if (wr && addr == A_GUARD)   guard <= wdata;
  end

  wire tx_go = wr && addr == A_DATA && !tx_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_busy <= 1'b0; tx_ph <= 1'b0; tx_cnt <= '0;
      tx_sh <= '1; tx_nb <= '0; tx_left <= '0;
    end else if (tx_go) begin
      tx_busy <= 1'b1; tx_ph <= 1'b0; tx_cnt <= '0; tx_nb <= '0;
      tx_sh   <= {^wdata, wdata, 1'b0};
      tx_left <= (guard == 8'd0) ? 8'd1 : guard;
    end else if (tx_busy && tick) begin
      if (tx_cnt == LST) begin
        tx_cnt <= '0;
        if (!tx_ph) begin
          tx_sh <= {1'b1, tx_sh[9:1]};
          if (tx_nb == 4'd9) tx_ph <= 1'b1;
          else tx_nb <= tx_nb + 1'b1;
        end else if (tx_left == 8'd1) tx_busy <= 1'b0;
        else tx_left <= tx_left - 1'b1;
      end else tx_cnt <= tx_cnt + 1'b1;
    end
  end

  assign txd = (tx_busy && !tx_ph) ? tx_sh[0] : 1'b1;

  always_comb begin
    case (addr)
      A_DATA:  rdata = empty ? 8'h00 : head[7:0];
      A_CTRL:  rdata = {7'b0, fifo_en};
      A_STAT:  rdata = stat;
      A_GUARD: rdata = guard;
      default: rdata = 8'h00;
    endcase
  end
endmodule

module serial_port_guard_chk #(
  parameter int DEPTH = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     rd,
  input logic                     wr,
  input logic [2:0]               addr,
  input logic                     txd,
  input logic                     push,
  input logic [$clog2(DEPTH):0]   fcnt,
  input logic                     ovr,
  input logic                     fifo_en,
  input logic                     tx_busy
);
  localparam int AW = $clog2(DEPTH);

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= (AW+1)'(DEPTH)); // R8
  AST_SINGLE_HOLDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> fcnt <= (AW+1)'(1)); // R9
  AST_FULL_DROP_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    push && fifo_en && fcnt == (AW+1)'(DEPTH) && !(rd && addr == 3'd0) && !(wr && addr == 3'd2)
    |=> ovr); // R8
  AST_STAT_CLEARS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    rd && addr == 3'd5 && !push |=> !ovr); // R7
  AST_COLLIDE_KEEPS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    rd && addr == 3'd5 && push && !fifo_en && fcnt != '0 && !(wr && addr == 3'd2) |=> ovr); // R10
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !push && !(rd && addr == 3'd0) && !(wr && addr == 3'd2) |=> $stable(fcnt)); // R1
  AST_TX_IDLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd); // R12
  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr && addr == 3'd0 && !tx_busy |=> !txd); // R12
endmodule

bind serial_port_guard serial_port_guard_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd(rd), .wr(wr), .addr(addr), .txd(txd),
  .push(push), .fcnt(fcnt), .ovr(ovr), .fifo_en(fifo_en), .tx_busy(tx_busy)
);

// File: tb/sim_serial_port_guard.sv
module sim_serial_port_guard;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rxd = 1'b1;
  logic wr = 1'b0, rd = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic txd;
  logic [7:0] rdata;
  int errs = 0, checks = 0;

  serial_port_guard u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .txd(txd),
    .addr(addr), .wr(wr), .rd(rd), .wdata(wdata), .rdata(rdata));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tk(input logic line, input logic srd);
    @(negedge clk); rxd = line; tick = 1'b1; rd = srd; if (srd) addr = 3'd5;
    @(negedge clk); tick = 1'b0; rd = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd = 1'b1; #1 v = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wreg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  function automatic logic fbit(input logic [7:0] d, input int idx, input logic bp, input logic bs);
    if (idx == 0) return 1'b0;
    if (idx <= 8) return d[idx-1];
    if (idx == 9) return (^d) ^ bp;
    return !bs;
  endfunction

  // stop bit of a frame is sampled on tick 168 counted from the start tick
  task automatic send(input logic [7:0] d, input logic bp, input logic bs, input int rd_at);
    for (int t = 0; t < 176; t++) tk(fbit(d, t/16, bp, bs), t == rd_at);
    for (int t = 0; t < 4; t++) tk(1'b1, 1'b0);
  endtask

  task automatic send_low(input int nbits);
    for (int t = 0; t < nbits*16; t++) tk(1'b0, 1'b0);
    for (int t = 0; t < 4; t++) tk(1'b1, 1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    rreg(3'd5, v); chk("R2 reset status", v, 8'h20);
    rreg(3'd2, v); chk("R2 reset ctrl", v, 8'h00);
    rreg(3'd0, v); chk("R2 reset data", v, 8'h00);
    rreg(3'd6, v); chk("R11 reset guard", v, 8'h01);

    wreg(3'd2, 8'h01);
    for (int i = 0; i < 256; i++) begin
      logic bp, bs;
      bp = (i % 5) == 1;
      bs = (i % 7) == 3;
      send(8'(i), bp, bs, -1);
      rreg(3'd5, v); chk("R1/R3/R4 status after frame", v, 8'h21 | (int'(bp) << 2) | (int'(bs) << 3));
      rreg(3'd5, v); chk("R7 flags cleared, ready kept", v, 8'h21);
      rreg(3'd0, v); chk("R1 data byte", v, i);
      rreg(3'd5, v); chk("R7 ready drops when empty", v, 8'h20);
    end

    wreg(3'd2, 8'h01);
    for (int k = 0; k < 17; k++) send(8'(8'h30 + k), 1'b0, 1'b0, -1);
    rreg(3'd5, v); chk("R8 full queue overrun", v, 8'h23);
    for (int k = 0; k < 16; k++) begin
      rreg(3'd0, v); chk("R8 queue order", v, 8'h30 + k);
    end
    rreg(3'd5, v); chk("R8 queue drained", v, 8'h20);

    send(8'h11, 1'b0, 1'b0, -1);
    send(8'h22, 1'b1, 1'b0, -1);
    rreg(3'd5, v); chk("R6 head clean", v, 8'h21);
    rreg(3'd0, v); chk("R6 first byte", v, 8'h11);
    rreg(3'd5, v); chk("R6 next head parity flag", v, 8'h25);
    rreg(3'd5, v); chk("R7 head flag cleared", v, 8'h21);
    rreg(3'd0, v); chk("R6 second byte", v, 8'h22);

    send_low(14);
    rreg(3'd5, v); chk("R5 silent flag", v, 8'h31);
    rreg(3'd0, v); chk("R5 silent data", v, 8'h00);
    rreg(3'd5, v); chk("R5 single entry", v, 8'h20);

    wreg(3'd2, 8'h00);
    rreg(3'd2, v); chk("R9 ctrl readback", v, 8'h00);
    send(8'h5A, 1'b0, 1'b0, -1);
    send(8'hA5, 1'b0, 1'b0, -1);
    rreg(3'd5, v); chk("R9 overwrite overrun", v, 8'h23);
    rreg(3'd0, v); chk("R9 newest byte kept", v, 8'hA5);
    rreg(3'd5, v); chk("R9 empty after read", v, 8'h20);

    send(8'h01, 1'b0, 1'b0, -1);
    send(8'h02, 1'b0, 1'b0, 168);
    rreg(3'd5, v); chk("R10 overrun survives same-cycle read", v, 8'h23);
    rreg(3'd0, v); chk("R10 byte", v, 8'h02);
    wreg(3'd2, 8'h01);
    send(8'h03, 1'b1, 1'b0, 168);
    rreg(3'd5, v); chk("R10 head flag survives same-cycle read", v, 8'h25);
    rreg(3'd0, v); chk("R10 byte in queue", v, 8'h03);

    begin
      int gl[5] = '{0, 1, 2, 3, 5};
      logic [7:0] dl[5] = '{8'hA7, 8'h3C, 8'h00, 8'hFF, 8'h81};
      for (int n = 0; n < 5; n++) begin
        int g, len;
        logic [7:0] d;
        g = gl[n]; d = dl[n];
        len = 16 * (10 + ((g == 0) ? 1 : g));
        wreg(3'd6, 8'(g));
        rreg(3'd6, v); chk("R11 guard readback", v, g);
        wreg(3'd0, d);
        for (int t = 0; t < len; t++) begin
          int idx;
          tk(1'b1, 1'b0);
          idx = t / 16;
          if (t == 20) wreg(3'd0, ~d);
          if (t % 16 == 8) chk("R12 tx line bit", txd, (idx >= 10) ? 1 : fbit(d, idx, 1'b0, 1'b0));
          if (t == len - 2) begin rreg(3'd5, v); chk("R12 busy before last stop ends", v[5], 0); end
          if (t == len - 1) begin rreg(3'd5, v); chk("R12 idle after guard time", v[5], 1); end
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule